// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block is the front stage of a small 32-bit processor whose instructions occupy one, two, five or six bytes. It owns the program counter (PC) and presents it on a byte-addressed instruction memory port. The memory returns six bytes starting at that address. From them the block separates the operation code, the function code, the two register specifiers and a 32-bit constant. It also computes the address that follows the current instruction and raises a flag when the encoding is not legal.

The first byte always carries the operation code in its upper nibble and the function code in its lower nibble. Whether a register byte follows depends on the operation code alone, and so does whether a four-byte constant follows. Both the instruction length and the sequential successor address come from those two facts. The PC is loaded from an external next-address input on any clock where the load enable is high. All decoded fields are combinational functions of the current PC and the returned bytes.

Top module: `vl_fetch`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabled load, `imem_addr` is 0.
- R2: On a rising clock edge with `pc_en` high, the PC takes the value of `pc_next`. `imem_addr` always shows the current PC.
- R3: On a rising clock edge with `pc_en` low, the PC keeps its value whatever `pc_next` holds.
- R4: Fetch byte i sits in `imem_bytes[8*i+7:8*i]`. `opc` is byte 0 bits 7:4 and `fnc` is byte 0 bits 3:0.
- R5: `ins_len` is 1 for opcodes 0 (no-op), 1 (halt) and 9 (return). It is 2 for opcodes 2 (register move), 6 (ALU), 10 (push) and 11 (pop). It is 5 for opcodes 7 (jump) and 8 (call). It is 6 for opcodes 3 (immediate load), 4 (store) and 5 (load).
- R6: For opcodes 2, 3, 4, 5, 6, 10 and 11, `reg_a` is byte 1 bits 7:4 and `reg_b` is byte 1 bits 3:0. For every other opcode both read 8, the value that means "no register".
- R7: `imm` is assembled little-endian. For opcodes 7 and 8 it comes from bytes 1 to 4. For opcodes 3, 4 and 5 it comes from bytes 2 to 5. For all other opcodes it is 0.
- R8: `seq_pc` equals the PC plus `ins_len`, modulo 2^32.
- R9: Opcodes 12 to 15 set `bad_instr`, report length 1 and carry no register byte or constant.
- R10: A nonzero function code sets `bad_instr` for every opcode from 0 to 11 except 6 and 7.
- R11: For opcode 6 a function code above 3 sets `bad_instr`. The legal codes are 0 add, 1 subtract, 2 and, 3 xor. For opcode 7 a function code above 6 sets `bad_instr`. The legal codes are 0 always, 1 less-or-equal, 2 less, 3 equal, 4 not-equal, 5 greater-or-equal, 6 greater.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_en | input | 1 | Load enable for the PC |
| pc_next | input | AW | Address loaded into the PC when enabled |
| imem_addr | output | AW | Current PC, used as the fetch address |
| imem_bytes | input | 8*(IMM_BYTES+2) | Bytes returned from the fetch address, byte 0 lowest |
| opc | output | 4 | Operation code |
| fnc | output | 4 | Function code |
| reg_a | output | 4 | First register specifier, 8 when absent |
| reg_b | output | 4 | Second register specifier, 8 when absent |
| imm | output | 8*IMM_BYTES | Constant field, 0 when absent |
| ins_len | output | 3 | Instruction length in bytes |
| seq_pc | output | AW | Address of the next sequential instruction |
| bad_instr | output | 1 | Illegal opcode or function code |

## Verification
The properties assume that `pc_en`, `pc_next` and `imem_bytes` carry known values at every sampled edge once reset is released. The length-derived properties also take the fetch bytes to be stable between edges, because the decoded fields follow them combinationally. The stimulus drives every input from the first instant, changes it only on the falling edge, and never leaves a bit undriven. Every possible first byte is swept with three different fills of the trailing bytes. Some loaded addresses sit just below the top of the address space, so the successor address wraps.

// File: rtl/vl_fetch_pkg.sv
package vl_fetch_pkg;

    localparam logic [3:0] REG_NONE   = 4'h8;
    localparam logic [3:0] ALU_FN_MAX = 4'd3;
    localparam logic [3:0] JMP_FN_MAX = 4'd6;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_MOVRR = 4'h2,
        OP_MOVIR = 4'h3,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    // Shape of an encoding: which optional parts follow byte 0, and legality.
    typedef struct packed {
        logic has_reg;
        logic has_imm;
        logic bad;
    } fmt_t;

endpackage

// File: rtl/vl_fetch_fmt.sv
module vl_fetch_fmt
    import vl_fetch_pkg::*;
(
    input  logic [3:0] opc,
    input  logic [3:0] fnc,
    output fmt_t       fmt
);

    always_comb begin
        fmt = '0;
        case (opc)
            OP_NOP, OP_HALT, OP_RET: begin
                fmt.bad = (fnc != 4'd0);
            end
            OP_MOVRR, OP_PUSH, OP_POP: begin
                fmt.has_reg = 1'b1;
                fmt.bad     = (fnc != 4'd0);
            end
            OP_ALU: begin
                fmt.has_reg = 1'b1;
                fmt.bad     = (fnc > ALU_FN_MAX);
            end
            OP_JUMP: begin
                fmt.has_imm = 1'b1;
                fmt.bad     = (fnc > JMP_FN_MAX);
            end
            OP_CALL: begin
                fmt.has_imm = 1'b1;
                fmt.bad     = (fnc != 4'd0);
            end
            OP_MOVIR, OP_STORE, OP_LOAD: begin
                fmt.has_reg = 1'b1;
                fmt.has_imm = 1'b1;
                fmt.bad     = (fnc != 4'd0);
            end
            default: begin
                fmt.bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/vl_fetch_extract.sv
module vl_fetch_extract
    import vl_fetch_pkg::*;
#(
    parameter int IMM_BYTES = 4
) (
    // Bytes 1 .. IMM_BYTES+1 of the fetch window; byte 1 in bits 7:0.
    input  logic [8*(IMM_BYTES+1)-1:0] tail_i,
    input  fmt_t                       fmt,
    output logic [3:0]                 reg_a,
    output logic [3:0]                 reg_b,
    output logic [8*IMM_BYTES-1:0]     imm
);

    always_comb begin
        reg_a = fmt.has_reg ? tail_i[7:4] : REG_NONE;
        reg_b = fmt.has_reg ? tail_i[3:0] : REG_NONE;
    end

    // The constant starts right after the register byte when one is present.
    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm
        always_comb begin
            if (!fmt.has_imm) begin
                imm[8*k +: 8] = 8'h00;
            end else if (fmt.has_reg) begin
                imm[8*k +: 8] = tail_i[8*(k+1) +: 8];
            end else begin
                imm[8*k +: 8] = tail_i[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/vl_fetch_pcreg.sv
module vl_fetch_pcreg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] nxt,
    output logic [AW-1:0] pc
);

    typedef struct packed {
        logic [AW-1:0] pc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.pc = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;

endmodule

// File: rtl/vl_fetch.sv
module vl_fetch
    import vl_fetch_pkg::*;
#(
    parameter int AW        = 32,
    parameter int IMM_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pc_en,
    input  logic [AW-1:0]               pc_next,
    output logic [AW-1:0]               imem_addr,
    input  logic [8*(IMM_BYTES+2)-1:0]  imem_bytes,
    output logic [3:0]                  opc,
    output logic [3:0]                  fnc,
    output logic [3:0]                  reg_a,
    output logic [3:0]                  reg_b,
    output logic [8*IMM_BYTES-1:0]      imm,
    output logic [2:0]                  ins_len,
    output logic [AW-1:0]               seq_pc,
    output logic                        bad_instr
);

    localparam int WIN_BYTES = IMM_BYTES + 2;
    localparam logic [2:0] IMM_LEN = 3'(IMM_BYTES);

    logic [AW-1:0] pc;
    fmt_t          fmt;

    vl_fetch_pcreg #(.AW(AW)) pcreg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pc_en),
        .nxt   (pc_next),
        .pc    (pc)
    );

    assign imem_addr = pc;
    assign opc       = imem_bytes[7:4];
    assign fnc       = imem_bytes[3:0];

    vl_fetch_fmt fmt_i (
        .opc (opc),
        .fnc (fnc),
        .fmt (fmt)
    );

    vl_fetch_extract #(.IMM_BYTES(IMM_BYTES)) ext_i (
        .tail_i (imem_bytes[8*WIN_BYTES-1:8]),
        .fmt    (fmt),
        .reg_a  (reg_a),
        .reg_b  (reg_b),
        .imm    (imm)
    );

    always_comb begin
        ins_len   = 3'd1 + {2'b00, fmt.has_reg} + (fmt.has_imm ? IMM_LEN : 3'd0);
        seq_pc    = pc + AW'(ins_len);
        bad_instr = fmt.bad;
    end

endmodule

// File: rtl/vl_fetch_chk.sv
module vl_fetch_chk #(
    parameter int AW        = 32,
    parameter int IMM_BYTES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pc_en,
    input logic [AW-1:0]          pc_next,
    input logic [AW-1:0]          imem_addr,
    input logic [3:0]             opc,
    input logic [3:0]             fnc,
    input logic [3:0]             reg_a,
    input logic [3:0]             reg_b,
    input logic [8*IMM_BYTES-1:0] imm,
    input logic [2:0]             ins_len,
    input logic [AW-1:0]          seq_pc,
    input logic                   bad_instr
);

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en |=> (imem_addr == $past(pc_next))); // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en |=> $stable(imem_addr)); // R3
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_len == 3'd1) || (ins_len == 3'd2) || (ins_len == 3'd5) || (ins_len == 3'd6)); // R5
    AST_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ((ins_len == 3'd1) || (ins_len == 3'd5)) |-> (reg_a == 4'h8) && (reg_b == 4'h8)); // R6
    AST_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_len < 3'd5) |-> (imm == '0)); // R7
    AST_SEQ_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        seq_pc == imem_addr + AW'(ins_len)); // R8
    AST_HIGH_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (opc > 4'hB) |-> bad_instr && (ins_len == 3'd1)); // R9
    AST_FN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc <= 4'hB) && (opc != 4'h6) && (opc != 4'h7) && (fnc != 4'h0)) |-> bad_instr); // R10
    AST_FN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (((opc == 4'h6) && (fnc > 4'd3)) || ((opc == 4'h7) && (fnc > 4'd6))) |-> bad_instr); // R11

endmodule

bind vl_fetch vl_fetch_chk #(.AW(AW), .IMM_BYTES(IMM_BYTES)) chk_i (.*);

// File: tb/vl_fetch_tb_top.sv
`timescale 1ns/1ps
module vl_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_en = 1'b0;
    logic [31:0] pc_next = 32'h0000_1234;
    logic [47:0] imem_bytes = '0;
    logic [31:0] imem_addr;
    logic [3:0]  opc, fnc, reg_a, reg_b;
    logic [31:0] imm;
    logic [2:0]  ins_len;
    logic [31:0] seq_pc;
    logic        bad_instr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vl_fetch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_en      (pc_en),
        .pc_next    (pc_next),
        .imem_addr  (imem_addr),
        .imem_bytes (imem_bytes),
        .opc        (opc),
        .fnc        (fnc),
        .reg_a      (reg_a),
        .reg_b      (reg_b),
        .imm        (imm),
        .ins_len    (ins_len),
        .seq_pc     (seq_pc),
        .bad_instr  (bad_instr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [47:0] w, input int i);
        return w[8*i +: 8];
    endfunction

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in reset", imem_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", imem_addr, 32'h0);

        for (int p = 0; p < 3; p++) begin
            for (int b = 0; b < 256; b++) begin
                logic [31:0] tgt;
                logic [3:0]  op, fn;
                int          len;
                logic        regp, immp, expbad;
                logic [3:0]  ea, eb;
                logic [31:0] eimm;
                int          base;

                tgt = (p == 2) ? (32'hFFFF_FFFC + 32'(b % 8)) : (32'(b) * 32'd1000 + 32'(p * 7));
                imem_bytes[7:0] = 8'(b);
                for (int k = 1; k < 6; k++)
                    imem_bytes[8*k +: 8] = 8'((b * 37 + p * 91 + k * 53 + 17) & 255);
                pc_next = tgt;
                pc_en = 1'b1;
                @(negedge clk);
                pc_en = 1'b0;
                chk("R2 load", imem_addr, tgt);

                op = 4'(b >> 4);
                fn = 4'(b & 15);
                chk("R4 opcode", {28'h0, opc}, {28'h0, op});
                chk("R4 function", {28'h0, fnc}, {28'h0, fn});

                regp = (op == 2) || (op == 3) || (op == 4) || (op == 5) || (op == 6) || (op == 10) || (op == 11);
                immp = (op == 3) || (op == 4) || (op == 5) || (op == 7) || (op == 8);
                len = 1 + (regp ? 1 : 0) + (immp ? 4 : 0);
                chk(op > 11 ? "R9 length" : "R5 length", {29'h0, ins_len}, 32'(len));

                ea = regp ? byte_of(imem_bytes, 1)[7:4] : 4'h8;
                eb = regp ? byte_of(imem_bytes, 1)[3:0] : 4'h8;
                chk("R6 reg_a", {28'h0, reg_a}, {28'h0, ea});
                chk("R6 reg_b", {28'h0, reg_b}, {28'h0, eb});

                base = regp ? 2 : 1;
                eimm = 32'h0;
                if (immp)
                    for (int k = 0; k < 4; k++)
                        eimm = eimm + (32'(byte_of(imem_bytes, base + k)) << (8 * k));
                chk("R7 constant", imm, eimm);

                chk("R8 successor", seq_pc, tgt + 32'(len));

                if (op > 11) begin
                    expbad = 1'b1;
                    chk("R9 illegal opcode", {31'h0, bad_instr}, 32'(expbad));
                end else if (op == 6) begin
                    expbad = (fn > 3);
                    chk("R11 alu code", {31'h0, bad_instr}, 32'(expbad));
                end else if (op == 7) begin
                    expbad = (fn > 6);
                    chk("R11 jump code", {31'h0, bad_instr}, 32'(expbad));
                end else begin
                    expbad = (fn != 0);
                    chk("R10 function zero", {31'h0, bad_instr}, 32'(expbad));
                end

                if ((b % 16) == 5) begin
                    held = imem_addr;
                    pc_next = ~tgt;
                    @(negedge clk);
                    chk("R3 hold", imem_addr, held);
                end
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule